// File: doc/BRIEF.md
# Error-Feedback Supply Voltage Governor

This block sets a supply-voltage code for a domain that runs at a fixed clock frequency. It treats correctable ECC events from one deliberately weak cache line as an early warning. It uses a narrow test port into the cache array. It writes a fixed 40-bit pattern (0x5A5A5A5A5A) into a line, reads it back, and observes the corrected data together with the correctable and uncorrectable flags that the array's ECC logic reports.

When enabled, the governor first runs a discovery pass. The pass probes every set/way location a fixed number of times and chooses the line that produced the most correctable events at the present voltage. It then enters its runtime phase, where only that line is probed. Probes are grouped into windows of a programmable length. At the end of each window, the count of correctable events is compared with a low and a high threshold. The code then moves one step down, moves one step up, or holds, always inside a programmable floor and ceiling. After each change, probing pauses for a programmable settle time.

An uncorrectable event, or read data that differs from the pattern without being flagged, is treated as a hard failure. It drives the code straight to the ceiling, sets a sticky alarm and restarts discovery. One instance serves one voltage domain. The cache array, its ECC codec and the regulator sit outside the block.

Top module: `vgov_top`

## Requirements
- R1: After reset, `vcode` is 210, `alarm` is 0, `mon_valid` is 0 and `tp_en` is 0.
- R2: Every probe is one write cycle (`tp_en`=1, `tp_we`=1, `tp_wdata`=0x5A5A5A5A5A) followed in the next cycle by a read cycle (`tp_en`=1, `tp_we`=0) of the same set and way. The response inputs are used in the cycle after the read.
- R3: Discovery probes each line PROBES times (default 4), in ascending order of {set, way}. It selects the line with the largest number of correctable events. On a tie it keeps the lowest set, then the lowest way. When the pass ends, `mon_valid` rises with `mon_set`/`mon_way` holding the selection.
- R4: While `mon_valid` is 1, every probe addresses `mon_set`/`mon_way`.
- R5: After `cfg_window` runtime probes, the window's correctable count is copied to `last_err`, and both window counters restart from zero.
- R6: At the end of a window, a count at or above `cfg_thr_max` raises `vcode` by one. Otherwise, a count at or below `cfg_thr_min` lowers it by one. Any other count leaves it unchanged.
- R7: A step up never takes `vcode` above `cfg_ceil`, and a step down never takes it below `cfg_floor`.
- R8: After any change of `vcode`, the next probe write appears `cfg_settle`+1 cycles after the first cycle that shows the new code.
- R9: A response with `tp_uncorr`=1, or with `tp_rdata` different from the pattern, sets `vcode` to `cfg_ceil` and `alarm` to 1 in the next cycle. The same cycle drops `mon_valid` to 0, and discovery restarts after the settle time. `alarm` stays 1 until reset.
- R10: With `enable` low, no probe is issued from the next cycle on, `vcode` holds, and `mon_valid` reads 0. Raising `enable` again starts a fresh discovery pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the governor |
| cfg_window | input | CNT_W | Runtime probes per evaluation window |
| cfg_thr_min | input | CNT_W | Count at or below which the code steps down |
| cfg_thr_max | input | CNT_W | Count at or above which the code steps up |
| cfg_floor | input | VC_W | Lowest code reachable by stepping |
| cfg_ceil | input | VC_W | Highest code; also the safe code after a failure |
| cfg_settle | input | SETTLE_W | Pause length after a code change |
| tp_en | output | 1 | Test port access strobe |
| tp_we | output | 1 | Test port write (1) or read (0) |
| tp_set | output | SET_W | Set index of the access |
| tp_way | output | WAY_W | Way index of the access |
| tp_wdata | output | DATA_W | Write data (test pattern) |
| tp_rdata | input | DATA_W | ECC-corrected read data, one cycle after a read |
| tp_corr | input | 1 | Correctable error flag for the read response |
| tp_uncorr | input | 1 | Uncorrectable error flag for the read response |
| vcode | output | VC_W | Supply voltage code |
| mon_valid | output | 1 | Runtime phase active; selection below is valid |
| mon_set | output | SET_W | Set index of the monitored line |
| mon_way | output | WAY_W | Way index of the monitored line |
| alarm | output | 1 | Sticky hard-failure indication |
| last_err | output | CNT_W | Correctable count of the last full window |

## Verification
The assertions assume that `cfg_ceil`, `cfg_floor` and the thresholds stay fixed while `enable` is high. They also assume that `tp_corr`, `tp_uncorr` and `tp_rdata` carry a response only in the cycle after a read strobe. The bench changes configuration only before reset is released. Its cache model registers a response exactly one cycle after each read and clears the flags in every other cycle. The model bases the discovery error counts on randomized per-line weakness values and bases the runtime counts on a selectable mode: none, all, or every other probe. This keeps every window's count a known value.

// File: rtl/vgov_pkg.sv
package vgov_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_CHK,
        ST_SETTLE
    } vg_state_e;

    localparam logic [39:0] VG_PATTERN = 40'h5A5A5A5A5A;
endpackage

// File: rtl/vgov_scan.sv
module vgov_scan #(
    parameter int SET_W  = 3,
    parameter int WAY_W  = 2,
    parameter int PROBES = 4,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             hit,
    output logic [SET_W-1:0] cur_set,
    output logic [WAY_W-1:0] cur_way,
    output logic             done,
    output logic [SET_W-1:0] pick_set,
    output logic [WAY_W-1:0] pick_way
);
    localparam int LINE_W = SET_W + WAY_W;
    localparam int LINES  = 1 << LINE_W;
    localparam int PRB_W  = (PROBES > 1) ? $clog2(PROBES) : 1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [PRB_W-1:0]  probe;
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W-1:0] best_line;
        logic [CNT_W-1:0]  best_cnt;
    } scan_t;

    scan_t q, d;
    logic             last_probe;
    logic [CNT_W-1:0] line_total;

    always_comb begin
        d          = q;
        last_probe = (q.probe == PRB_W'(PROBES - 1));
        line_total = q.cnt + CNT_W'(hit);
        done       = tick && last_probe && (q.line == LINE_W'(LINES - 1));
        if (clr) begin
            d = '0;
        end else if (tick) begin
            if (last_probe) begin
                // strict compare keeps the earliest line on a tie
                if (line_total > q.best_cnt) begin
                    d.best_line = q.line;
                    d.best_cnt  = line_total;
                end
                d.cnt   = '0;
                d.probe = '0;
                d.line  = q.line + 1'b1;
            end else begin
                d.probe = q.probe + 1'b1;
                d.cnt   = line_total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_set  = q.line[LINE_W-1:WAY_W];
    assign cur_way  = q.line[WAY_W-1:0];
    assign pick_set = d.best_line[LINE_W-1:WAY_W];
    assign pick_way = d.best_line[WAY_W-1:0];
endmodule

// File: rtl/vgov_window.sv
module vgov_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             hit,
    input  logic [CNT_W-1:0] cfg_window,
    output logic             done,
    output logic [CNT_W-1:0] total
);
    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] err;
    } win_t;

    win_t q, d;

    always_comb begin
        d     = q;
        total = q.err + CNT_W'(hit);
        done  = tick && (({1'b0, q.acc} + 1'b1) >= {1'b0, cfg_window});
        if (clr || done) begin
            d = '0;
        end else if (tick) begin
            d.acc = q.acc + 1'b1;
            d.err = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vgov_top.sv
module vgov_top
    import vgov_pkg::*;
#(
    parameter int SET_W    = 3,
    parameter int WAY_W    = 2,
    parameter int PROBES   = 4,
    parameter int CNT_W    = 16,
    parameter int VC_W     = 8,
    parameter int SETTLE_W = 8,
    parameter int DATA_W   = 40,
    parameter logic [DATA_W-1:0] PATTERN  = DATA_W'(VG_PATTERN),
    parameter logic [VC_W-1:0]   VC_RESET = VC_W'(210)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [CNT_W-1:0]    cfg_window,
    input  logic [CNT_W-1:0]    cfg_thr_min,
    input  logic [CNT_W-1:0]    cfg_thr_max,
    input  logic [VC_W-1:0]     cfg_floor,
    input  logic [VC_W-1:0]     cfg_ceil,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic                tp_en,
    output logic                tp_we,
    output logic [SET_W-1:0]    tp_set,
    output logic [WAY_W-1:0]    tp_way,
    output logic [DATA_W-1:0]   tp_wdata,
    input  logic [DATA_W-1:0]   tp_rdata,
    input  logic                tp_corr,
    input  logic                tp_uncorr,
    output logic [VC_W-1:0]     vcode,
    output logic                mon_valid,
    output logic [SET_W-1:0]    mon_set,
    output logic [WAY_W-1:0]    mon_way,
    output logic                alarm,
    output logic [CNT_W-1:0]    last_err
);
    typedef struct packed {
        vg_state_e          st;
        logic [VC_W-1:0]    vcode;
        logic               alarm;
        logic               mon_valid;
        logic [SET_W-1:0]   mon_set;
        logic [WAY_W-1:0]   mon_way;
        logic [CNT_W-1:0]   last_err;
        logic [SETTLE_W-1:0] settle;
    } ctl_t;

    ctl_t q, d;

    logic             chk, fault, disc_tick, run_tick, scan_clr, win_clr;
    logic [SET_W-1:0] scan_set, pick_set;
    logic [WAY_W-1:0] scan_way, pick_way;
    logic             scan_done, win_done;
    logic [CNT_W-1:0] win_total;
    logic [VC_W-1:0]  code_new;

    assign chk       = (q.st == ST_CHK);
    assign fault     = chk && (tp_uncorr || (tp_rdata != PATTERN));
    assign disc_tick = chk && !fault && !q.mon_valid;
    assign run_tick  = chk && !fault && q.mon_valid;
    assign scan_clr  = (q.st == ST_IDLE) || fault;
    assign win_clr   = (q.st == ST_IDLE) || fault || !q.mon_valid;

    vgov_scan #(
        .SET_W(SET_W), .WAY_W(WAY_W), .PROBES(PROBES), .CNT_W(CNT_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(scan_clr), .tick(disc_tick), .hit(tp_corr),
        .cur_set(scan_set), .cur_way(scan_way), .done(scan_done),
        .pick_set(pick_set), .pick_way(pick_way)
    );

    vgov_window #(
        .CNT_W(CNT_W)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .clr(win_clr), .tick(run_tick), .hit(tp_corr),
        .cfg_window(cfg_window), .done(win_done), .total(win_total)
    );

    always_comb begin
        code_new = q.vcode;
        if (win_total >= cfg_thr_max) begin
            if (q.vcode < cfg_ceil) code_new = q.vcode + 1'b1;
        end else if (win_total <= cfg_thr_min) begin
            if (q.vcode > cfg_floor) code_new = q.vcode - 1'b1;
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE:   if (enable) d.st = ST_WR;
            ST_WR:     d.st = ST_RD;
            ST_RD:     d.st = ST_CHK;
            ST_CHK: begin
                d.st = ST_WR;
                if (fault) begin
                    d.vcode     = cfg_ceil;
                    d.alarm     = 1'b1;
                    d.mon_valid = 1'b0;
                    d.settle    = cfg_settle;
                    d.st        = ST_SETTLE;
                end else if (!q.mon_valid) begin
                    if (scan_done) begin
                        d.mon_valid = 1'b1;
                        d.mon_set   = pick_set;
                        d.mon_way   = pick_way;
                    end
                end else if (win_done) begin
                    d.last_err = win_total;
                    d.vcode    = code_new;
                    if (code_new != q.vcode) begin
                        d.settle = cfg_settle;
                        d.st     = ST_SETTLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (q.settle == '0) d.st = ST_WR;
                else                d.settle = q.settle - 1'b1;
            end
            default:   d.st = ST_IDLE;
        endcase
        if (!enable) begin
            d.st        = ST_IDLE;
            d.mon_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.vcode <= VC_RESET;
        end else begin
            q <= d;
        end
    end

    assign tp_en     = (q.st == ST_WR) || (q.st == ST_RD);
    assign tp_we     = (q.st == ST_WR);
    assign tp_set    = q.mon_valid ? q.mon_set : scan_set;
    assign tp_way    = q.mon_valid ? q.mon_way : scan_way;
    assign tp_wdata  = PATTERN;
    assign vcode     = q.vcode;
    assign mon_valid = q.mon_valid;
    assign mon_set   = q.mon_set;
    assign mon_way   = q.mon_way;
    assign alarm     = q.alarm;
    assign last_err  = q.last_err;
endmodule

// File: rtl/vgov_chk.sv
module vgov_chk #(
    parameter int SET_W  = 3,
    parameter int WAY_W  = 2,
    parameter int VC_W   = 8,
    parameter int DATA_W = 40,
    parameter logic [DATA_W-1:0] PATTERN = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [VC_W-1:0]   cfg_ceil,
    input logic              tp_en,
    input logic              tp_we,
    input logic [SET_W-1:0]  tp_set,
    input logic [WAY_W-1:0]  tp_way,
    input logic [DATA_W-1:0] tp_wdata,
    input logic              tp_uncorr,
    input logic [VC_W-1:0]   vcode,
    input logic              mon_valid,
    input logic [SET_W-1:0]  mon_set,
    input logic [WAY_W-1:0]  mon_way,
    input logic              alarm
);
    AST_WRITE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_en && tp_we) |-> (tp_wdata == PATTERN)); // R2
    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_en && tp_we && enable) |=> (tp_en && !tp_we && $stable(tp_set) && $stable(tp_way))); // R2
    AST_RUN_LINE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && tp_en) |-> (tp_set == mon_set && tp_way == mon_way)); // R4
    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode != $past(vcode)) |-> (vcode == $past(vcode) + 1'b1 || vcode == $past(vcode) - 1'b1 || vcode == cfg_ceil)); // R6
    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode != $past(vcode)) |-> !tp_en); // R8
    AST_UNCORR_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tp_en && !tp_we && enable) && tp_uncorr) |=> (vcode == cfg_ceil && alarm && !mon_valid)); // R9
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alarm) |-> alarm); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tp_en && !mon_valid)); // R10
endmodule

bind vgov_top vgov_chk #(
    .SET_W(SET_W), .WAY_W(WAY_W), .VC_W(VC_W), .DATA_W(DATA_W), .PATTERN(PATTERN)
) u_vgov_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_ceil(cfg_ceil),
    .tp_en(tp_en), .tp_we(tp_we), .tp_set(tp_set), .tp_way(tp_way),
    .tp_wdata(tp_wdata), .tp_uncorr(tp_uncorr), .vcode(vcode),
    .mon_valid(mon_valid), .mon_set(mon_set), .mon_way(mon_way), .alarm(alarm)
);

// File: tb/tb_vgov_top.sv
module tb_vgov_top;
    localparam int CLK_PERIOD = 10;
    localparam int SET_W = 3, WAY_W = 2, PROBES = 4, CNT_W = 16, VC_W = 8, SETTLE_W = 8, DATA_W = 40;
    localparam int LINES = 1 << (SET_W + WAY_W);
    localparam logic [DATA_W-1:0] PAT = 40'h5A5A5A5A5A;
    localparam int WIN = 8, TMIN = 1, TMAX = 6, FLOOR = 150, CEIL = 220, SETTLE = 5;

    logic clk = 0, rst_n = 0, enable = 0;
    logic [CNT_W-1:0] cfg_window = CNT_W'(WIN), cfg_thr_min = CNT_W'(TMIN), cfg_thr_max = CNT_W'(TMAX);
    logic [VC_W-1:0] cfg_floor = VC_W'(FLOOR), cfg_ceil = VC_W'(CEIL);
    logic [SETTLE_W-1:0] cfg_settle = SETTLE_W'(SETTLE);
    logic tp_en, tp_we, tp_corr, tp_uncorr, mon_valid, alarm;
    logic [SET_W-1:0] tp_set, mon_set;
    logic [WAY_W-1:0] tp_way, mon_way;
    logic [DATA_W-1:0] tp_wdata, tp_rdata;
    logic [VC_W-1:0] vcode;
    logic [CNT_W-1:0] last_err;

    vgov_top dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int w [LINES];
    int rt_mode = 0;
    logic inj_unc = 0, corrupt = 0;
    int disc_cnt = 0, rt_cnt = 0;
    int v2 = 0, v4 = 0;
    logic pend = 0;
    logic [SET_W+WAY_W-1:0] pend_line;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_best();
        int best = 0;
        for (int i = 1; i < LINES; i++) if (w[i] > w[best]) best = i;
        return best;
    endfunction

    // cache array model with ECC flags
    always @(posedge clk) begin
        logic rd;
        rd = tp_en && !tp_we;
        if (!enable || mon_valid) disc_cnt <= 0;
        else if (rd) disc_cnt <= disc_cnt + 1;
        if (mon_valid && rd) rt_cnt <= rt_cnt + 1;
        if (rd) begin
            tp_rdata  <= PAT ^ (corrupt ? 40'h1 : 40'h0);
            tp_uncorr <= inj_unc;
            if (!mon_valid) tp_corr <= ((disc_cnt % PROBES) < w[{tp_set, tp_way}]);
            else tp_corr <= (rt_mode == 1) || (rt_mode == 2 && rt_cnt[0]);
        end else begin
            tp_corr   <= 1'b0;
            tp_uncorr <= 1'b0;
        end
    end

    // probe protocol monitors
    always @(negedge clk) if (rst_n) begin
        if (pend && tp_en && (tp_we || {tp_set, tp_way} != pend_line)) v2++;
        pend <= 1'b0;
        if (tp_en && tp_we) begin
            if (tp_wdata != PAT) v2++;
            pend <= 1'b1;
            pend_line <= {tp_set, tp_way};
        end
        if (mon_valid && tp_en && (tp_set != mon_set || tp_way != mon_way)) v4++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic wait_mon(input logic val);
        int g = 0;
        while (mon_valid !== val && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic wait_code(input int code);
        int g = 0;
        while (vcode != VC_W'(code) && g < 20000) begin @(negedge clk); g++; end
    endtask

    initial begin
        int best;
        logic [VC_W-1:0] held;
        void'($urandom(32'h5eed_1234));
        tp_rdata = PAT; tp_corr = 0; tp_uncorr = 0;
        for (int i = 0; i < LINES; i++) w[i] = 0;
        repeat (3) @(negedge clk);
        check(vcode == 8'd210, "R1 vcode", vcode, 210);
        check(alarm == 0 && mon_valid == 0, "R1 flags", {alarm, mon_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        check(tp_en == 0, "R1 tp_en", tp_en, 0);

        // R3 discovery: random weakness, all-zero and forced ties
        for (int r = 0; r < 6; r++) begin
            enable = 0;
            repeat (3) @(negedge clk);
            check(tp_en == 0 && mon_valid == 0, "R10 idle", {tp_en, mon_valid}, 0);
            for (int i = 0; i < LINES; i++) w[i] = (r == 1) ? 0 : int'($urandom_range(0, PROBES - 1));
            if (r == 2) begin w[9] = PROBES; w[22] = PROBES; end
            if (r == 3) begin w[13] = PROBES; w[14] = PROBES; end
            best = expect_best();
            enable = 1;
            wait_mon(1'b1);
            check({mon_set, mon_way} == best[SET_W+WAY_W-1:0], "R3 pick", {mon_set, mon_way}, best);
        end

        // R6/R7 step down to floor, R5 empty windows
        rt_mode = 0;
        repeat (400) @(negedge clk);
        // R10 enable low mid-run holds the code
        enable = 0;
        @(negedge clk);
        held = vcode;
        check(tp_en == 0, "R10 stop", tp_en, 0);
        repeat (60) @(negedge clk);
        check(vcode == held && mon_valid == 0, "R10 hold", vcode, held);
        enable = 1;
        wait_mon(1'b1);
        wait_code(FLOOR);
        check(vcode == FLOOR, "R7 floor reached", vcode, FLOOR);
        repeat (300) @(negedge clk);
        check(vcode == FLOOR, "R7 floor saturate", vcode, FLOOR);
        check(last_err == 0, "R5 zero window", last_err, 0);

        // R6 hold band: 4 errors per window between thresholds
        rt_mode = 2;
        repeat (60) @(negedge clk);
        held = vcode;
        repeat (300) @(negedge clk);
        check(vcode == held, "R6 hold", vcode, held);
        check(last_err == 4, "R5 half window", last_err, 4);

        // R9 uncorrectable response
        inj_unc = 1;
        begin int g = 0; while (!alarm && g < 2000) begin @(negedge clk); g++; end end
        inj_unc = 0;
        check(vcode == CEIL, "R9 safe code", vcode, CEIL);
        check(mon_valid == 0, "R9 rediscover", mon_valid, 0);
        wait_mon(1'b1);
        check(alarm == 1, "R9 sticky", alarm, 1);

        // go down a few steps, then R8 settle gap while climbing
        rt_mode = 0;
        wait_code(CEIL - 5);
        rt_mode = 1;
        begin
            int n = 0, g = 0;
            held = vcode;
            while (vcode == held && g < 2000) begin @(negedge clk); g++; end
            check(vcode == held + 1, "R6 step up", vcode, held + 1);
            while (n < 100) begin @(negedge clk); n++; if (tp_en) break; end
            check(n == SETTLE + 1, "R8 settle gap", n, SETTLE + 1);
        end
        wait_code(CEIL);
        repeat (300) @(negedge clk);
        check(vcode == CEIL, "R7 ceil saturate", vcode, CEIL);
        check(last_err == WIN, "R5 full window", last_err, WIN);

        // R9 silent data corruption
        rt_mode = 0;
        wait_code(CEIL - 3);
        corrupt = 1;
        wait_mon(1'b0);
        corrupt = 0;
        check(vcode == CEIL, "R9 corrupt safe", vcode, CEIL);

        check(v2 == 0, "R2 protocol", v2, 0);
        check(v4 == 0, "R4 line only", v4, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule